// File: doc/BRIEF.md
# Stable-Gated System Clock Switcher

This block picks the system clock from four sources: an external crystal, a PLL output, a slow internal oscillator of about 10 kHz, and a fast internal oscillator of about 22 MHz. Software selects a source with a 3-bit code and turns each source on or off with an enable bit. Both kinds of write are accepted only while a write-protect unlock input is high. Each source also supplies a raw "stable" signal. The block combines that signal with the source's enable to report a per-source ready flag.

When a new code is written, the system clock stays on the source that currently drives it. The block waits until three things are true: the requested source is ready, the current source is enabled, and the requested source is enabled. Only then does it hand over. The handover cannot produce a glitch. Each source has a gating cell in its own clock domain. The old cell closes its gate on a falling edge of its own clock. The new cell opens its gate on one of its own falling edges only after it has seen, through a synchronizer, that every other gate is closed. A mismatch flag stays high while the active source differs from the selected one.

On reset the selection reloads from a 3-bit configuration input, so the chip starts on the crystal or on the fast internal oscillator.

Top module: `sysclk_switch`

## Requirements
- R1: On reset, the selection code becomes 000 if the configuration input is 000, and 111 for any other configuration value. The enables reset to the fast oscillator (bit 3) on and the crystal (bit 0) on only when the reset code is 000; the PLL (bit 1) and the slow oscillator (bit 2) start off. No gate is open right after reset.
- R2: The legal select codes are 000 = crystal, 010 = PLL, 011 = slow oscillator and 111 = fast oscillator. While unlocked, a select write with a legal code updates the selection code output.
- R3: A select write of 001 (reserved), 100, 101 or 110 is ignored, and the previous selection is kept.
- R4: While the unlock input is low, select writes and enable writes have no effect.
- R5: Ready bit i (in source bit order crystal=0, PLL=1, slow=2, fast=3) reads 1 only when source i is enabled and its raw stable input is high. It reads 0 if the source is disabled, even when the raw stable input is high.
- R6: After a new legal code is written, the active source stays the old one until the requested source is ready. The handover then completes without further writes.
- R7: A handover does not complete while either the requested source or the currently active source is disabled. It completes after both are enabled.
- R8: The mismatch flag reads 1 while the active-source one-hot output differs from the one-hot form of the selection code, including when no gate is open. It reads 0 when they match.
- R9: At most one source gate is open at any time. Every high or low phase of the system clock lasts at least one half period of the source that drives it.
- R10: If the active source's raw stable input drops, the block stays on that source and does not move to any other one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Register-side clock |
| rst_n | input | 1 | Active-low asynchronous reset for all domains |
| cfg_sel | input | 3 | Configuration code reloaded into the selection on reset |
| unlock | input | 1 | Write-protect unlock, high allows writes |
| sel_wr | input | 1 | Select write strobe |
| sel_wdata | input | 3 | Select write code |
| en_wr | input | 1 | Enable write strobe |
| en_wdata | input | 4 | Enable write value, one bit per source |
| src_clk | input | 4 | Source clocks |
| src_stable | input | 4 | Raw stable indication per source |
| sys_clk | output | 1 | Glitch-free system clock |
| sel_code | output | 3 | Current selection code |
| src_en | output | 4 | Source enable bits |
| src_ready | output | 4 | Per-source ready flags |
| active_src | output | 4 | One-hot active source, synchronized to clk |
| sw_fail | output | 1 | Mismatch between selected and active source |

## Verification
The bench makes the requested source unstable. A design that switched anyway would move the active output too early and clear the mismatch flag. It then disables the requested source, and in a separate case the current source. A design that ignored the enable check could hang on a stopped clock, or would show the handover completing early. The bench writes the reserved and undefined codes, and writes while locked. A design that let these through would change the selection output and start a switch. It also drops the active source's stable input, where a design that fell back would move the active output. Throughout the run, a monitor times every system-clock phase. A gate that opened off a falling edge, or two gates open at once, would show as a short phase.

// File: rtl/sysclk_switch_pkg.sv
package sysclk_switch_pkg;

    localparam int NUM_SRC = 4;
    localparam int CODE_W  = 3;

    // source bit positions in every per-source vector
    localparam int IDX_XTAL = 0;
    localparam int IDX_PLL  = 1;
    localparam int IDX_SLOW = 2;
    localparam int IDX_FAST = 3;

    typedef enum logic [CODE_W-1:0] {
        CODE_XTAL = 3'b000,
        CODE_PLL  = 3'b010,
        CODE_SLOW = 3'b011,
        CODE_FAST = 3'b111
    } src_code_e;

    typedef struct packed {
        logic [CODE_W-1:0]  sel;
        logic [NUM_SRC-1:0] en;
        logic [NUM_SRC-1:0] rdy;
        logic [NUM_SRC-1:0] want;
    } ctl_state_t;

    function automatic logic code_ok(input logic [CODE_W-1:0] c);
        case (c)
            CODE_XTAL, CODE_PLL, CODE_SLOW, CODE_FAST: code_ok = 1'b1;
            default:                                   code_ok = 1'b0;
        endcase
    endfunction

    function automatic logic [NUM_SRC-1:0] code_to_oh(input logic [CODE_W-1:0] c);
        logic [NUM_SRC-1:0] oh;
        oh = '0;
        case (c)
            CODE_XTAL: oh[IDX_XTAL] = 1'b1;
            CODE_PLL:  oh[IDX_PLL]  = 1'b1;
            CODE_SLOW: oh[IDX_SLOW] = 1'b1;
            CODE_FAST: oh[IDX_FAST] = 1'b1;
            default:   oh = '0;
        endcase
        return oh;
    endfunction

    function automatic logic [CODE_W-1:0] boot_code(input logic [CODE_W-1:0] cfg);
        return (cfg == CODE_XTAL) ? CODE_XTAL : CODE_FAST;
    endfunction

    function automatic logic [NUM_SRC-1:0] boot_en(input logic [CODE_W-1:0] cfg);
        logic [NUM_SRC-1:0] e;
        e = '0;
        e[IDX_FAST] = 1'b1;
        e[IDX_XTAL] = (cfg == CODE_XTAL);
        return e;
    endfunction

endpackage

// File: rtl/clksw_sync.sv
module clksw_sync #(
    parameter int WIDTH  = 1,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] d,
    output logic [WIDTH-1:0] q
);

    logic [WIDTH-1:0] stg_q [STAGES];
    logic [WIDTH-1:0] stg_d [STAGES];

    always_comb begin
        stg_d[0] = d;
        for (int s = 1; s < STAGES; s++) begin
            stg_d[s] = stg_q[s-1];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int s = 0; s < STAGES; s++) begin
                stg_q[s] <= '0;
            end
        end else begin
            for (int s = 0; s < STAGES; s++) begin
                stg_q[s] <= stg_d[s];
            end
        end
    end

    assign q = stg_q[STAGES-1];

endmodule

// File: rtl/clksw_gate.sv
module clksw_gate #(
    parameter int SYNC_STAGES = 2
) (
    input  logic src_clk,
    input  logic rst_n,
    input  logic want,
    input  logic others_on,
    output logic gate_on,
    output logic clk_out
);

    logic [1:0] req_s;
    logic       open_d;
    logic       open_q;

    // both control inputs arrive from foreign domains
    clksw_sync #(
        .WIDTH  (2),
        .STAGES (SYNC_STAGES)
    ) u_req_sync (
        .clk   (src_clk),
        .rst_n (rst_n),
        .d     ({others_on, want}),
        .q     (req_s)
    );

    always_comb begin
        open_d = req_s[0] & ~req_s[1];
    end

    // gate state only moves while this clock is low
    always_ff @(negedge src_clk or negedge rst_n) begin
        if (!rst_n) begin
            open_q <= 1'b0;
        end else begin
            open_q <= open_d;
        end
    end

    assign gate_on = open_q;
    assign clk_out = src_clk & open_q;

endmodule

// File: rtl/clksw_ctl.sv
module clksw_ctl
    import sysclk_switch_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [CODE_W-1:0]  cfg_sel,
    input  logic               unlock,
    input  logic               sel_wr,
    input  logic [CODE_W-1:0]  sel_wdata,
    input  logic               en_wr,
    input  logic [NUM_SRC-1:0] en_wdata,
    input  logic [NUM_SRC-1:0] src_stable,
    output logic [CODE_W-1:0]  sel_q,
    output logic [NUM_SRC-1:0] en_q,
    output logic [NUM_SRC-1:0] rdy_q,
    output logic [NUM_SRC-1:0] want_q
);

    ctl_state_t         cur_q;
    ctl_state_t         nxt_d;
    logic [NUM_SRC-1:0] stab_s;
    logic [NUM_SRC-1:0] tgt_oh;
    logic               cur_ok;

    clksw_sync #(
        .WIDTH  (NUM_SRC),
        .STAGES (SYNC_STAGES)
    ) u_stab_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d     (src_stable),
        .q     (stab_s)
    );

    always_comb begin
        nxt_d     = cur_q;
        nxt_d.rdy = cur_q.en & stab_s;
        if (unlock && sel_wr && code_ok(sel_wdata)) begin
            nxt_d.sel = sel_wdata;
        end
        if (unlock && en_wr) begin
            nxt_d.en = en_wdata;
        end
        tgt_oh = code_to_oh(cur_q.sel);
        cur_ok = (cur_q.want == '0) || ((cur_q.want & cur_q.en) != '0);
        if ((cur_q.want != tgt_oh) && ((tgt_oh & cur_q.rdy) != '0) && cur_ok) begin
            nxt_d.want = tgt_oh;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cur_q.sel  <= boot_code(cfg_sel);
            cur_q.en   <= boot_en(cfg_sel);
            cur_q.rdy  <= '0;
            cur_q.want <= '0;
        end else begin
            cur_q <= nxt_d;
        end
    end

    assign sel_q  = cur_q.sel;
    assign en_q   = cur_q.en;
    assign rdy_q  = cur_q.rdy;
    assign want_q = cur_q.want;

    AST_SEL_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
        code_ok(sel_q)); // R3

    AST_LOCK_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !unlock |=> ($stable(sel_q) && $stable(en_q))); // R4

    AST_SWITCH_WAITS_READY: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(want_q) |-> ((want_q & $past(rdy_q)) != '0)); // R6

    AST_BOTH_ENABLED: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(want_q) |-> (($past(want_q) == '0) || (($past(want_q) & $past(en_q)) != '0))); // R7

    AST_NO_FALLBACK: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(want_q) |-> (want_q == code_to_oh($past(sel_q)))); // R10

endmodule

// File: rtl/sysclk_switch.sv
module sysclk_switch
    import sysclk_switch_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [2:0]         cfg_sel,
    input  logic               unlock,
    input  logic               sel_wr,
    input  logic [2:0]         sel_wdata,
    input  logic               en_wr,
    input  logic [3:0]         en_wdata,
    input  logic [3:0]         src_clk,
    input  logic [3:0]         src_stable,
    output logic               sys_clk,
    output logic [2:0]         sel_code,
    output logic [3:0]         src_en,
    output logic [3:0]         src_ready,
    output logic [3:0]         active_src,
    output logic               sw_fail
);

    logic [CODE_W-1:0]  sel_q;
    logic [NUM_SRC-1:0] en_q;
    logic [NUM_SRC-1:0] rdy_q;
    logic [NUM_SRC-1:0] want_q;
    logic [NUM_SRC-1:0] gate_all;
    logic [NUM_SRC-1:0] gclk;
    logic [NUM_SRC-1:0] active_s;
    logic               fail_d;

    clksw_ctl #(
        .SYNC_STAGES (SYNC_STAGES)
    ) u_ctl (
        .clk        (clk),
        .rst_n      (rst_n),
        .cfg_sel    (cfg_sel),
        .unlock     (unlock),
        .sel_wr     (sel_wr),
        .sel_wdata  (sel_wdata),
        .en_wr      (en_wr),
        .en_wdata   (en_wdata),
        .src_stable (src_stable),
        .sel_q      (sel_q),
        .en_q       (en_q),
        .rdy_q      (rdy_q),
        .want_q     (want_q)
    );

    for (genvar i = 0; i < NUM_SRC; i++) begin : g_src
        localparam logic [NUM_SRC-1:0] SELF_MASK = NUM_SRC'(1) << i;
        logic others_on;

        assign others_on = (gate_all & ~SELF_MASK) != '0;

        clksw_gate #(
            .SYNC_STAGES (SYNC_STAGES)
        ) u_gate (
            .src_clk   (src_clk[i]),
            .rst_n     (rst_n),
            .want      (want_q[i]),
            .others_on (others_on),
            .gate_on   (gate_all[i]),
            .clk_out   (gclk[i])
        );
    end

    clksw_sync #(
        .WIDTH  (NUM_SRC),
        .STAGES (SYNC_STAGES)
    ) u_act_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d     (gate_all),
        .q     (active_s)
    );

    always_comb begin
        fail_d = (active_s != code_to_oh(sel_q));
    end

    assign sys_clk    = |gclk;
    assign sel_code   = sel_q;
    assign src_en     = en_q;
    assign src_ready  = rdy_q;
    assign active_src = active_s;
    assign sw_fail    = fail_d;

    AST_GATES_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(gate_all)); // R9

    AST_GATE_FOLLOWS_REQUEST: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(active_s != '0) |-> (want_q != '0)); // R6

endmodule

// File: tb/sysclk_switch_bench.sv
module sysclk_switch_bench;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [2:0] cfg_sel = 3'b111;
    logic       unlock = 1'b0;
    logic       sel_wr = 1'b0;
    logic [2:0] sel_wdata = 3'b000;
    logic       en_wr = 1'b0;
    logic [3:0] en_wdata = 4'b0000;
    logic       sc0 = 1'b0, sc1 = 1'b0, sc2 = 1'b0, sc3 = 1'b0;
    logic [3:0] src_clk;
    logic [3:0] src_stable = 4'b1111;
    logic       sys_clk;
    logic [2:0] sel_code;
    logic [3:0] src_en;
    logic [3:0] src_ready;
    logic [3:0] active_src;
    logic       sw_fail;

    int checks = 0;
    int failures = 0;
    int glitches = 0;
    longint last_edge = 0;

    // 8-unit period register clock; source half periods 5, 7, 20, 9
    always #4 clk = ~clk;
    always #5 sc0 = ~sc0;
    always #7 sc1 = ~sc1;
    always #20 sc2 = ~sc2;
    always #9 sc3 = ~sc3;
    assign src_clk = {sc3, sc2, sc1, sc0};

    sysclk_switch u_sysclk_switch (
        .clk        (clk),
        .rst_n      (rst_n),
        .cfg_sel    (cfg_sel),
        .unlock     (unlock),
        .sel_wr     (sel_wr),
        .sel_wdata  (sel_wdata),
        .en_wr      (en_wr),
        .en_wdata   (en_wdata),
        .src_clk    (src_clk),
        .src_stable (src_stable),
        .sys_clk    (sys_clk),
        .sel_code   (sel_code),
        .src_en     (src_en),
        .src_ready  (src_ready),
        .active_src (active_src),
        .sw_fail    (sw_fail)
    );

    // phase-width monitor for R9: shortest legal phase is 5 units
    always @(sys_clk) begin
        if (rst_n) begin
            if (($time - last_edge) < 5) glitches++;
        end
        last_edge = $time;
    end
    always @(posedge rst_n) last_edge = $time;

    // code, expected selection, expected active one-hot
    localparam logic [9:0] VECS [7] = '{
        {3'b010, 3'b010, 4'b0010},
        {3'b001, 3'b010, 4'b0010},
        {3'b011, 3'b011, 4'b0100},
        {3'b101, 3'b011, 4'b0100},
        {3'b000, 3'b000, 4'b0001},
        {3'b111, 3'b111, 4'b1000},
        {3'b110, 3'b111, 4'b1000}
    };

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic settle();
        repeat (120) @(posedge clk);
        @(negedge clk);
    endtask

    task automatic do_reset(input logic [2:0] cfg);
        @(negedge clk);
        rst_n = 1'b0;
        cfg_sel = cfg;
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
    endtask

    task automatic wr_sel(input logic [2:0] code);
        @(negedge clk);
        sel_wr = 1'b1;
        sel_wdata = code;
        @(negedge clk);
        sel_wr = 1'b0;
    endtask

    task automatic wr_en(input logic [3:0] val);
        @(negedge clk);
        en_wr = 1'b1;
        en_wdata = val;
        @(negedge clk);
        en_wr = 1'b0;
    endtask

    task automatic run_all();
        // reset from fast oscillator configuration
        do_reset(3'b111);
        chk("R1 sel after reset", 32'(sel_code), 32'h7);
        chk("R1 enables after reset", 32'(src_en), 32'h8);
        chk("R1 no gate open", 32'(active_src), 32'h0);
        chk("R8 fail with no gate", 32'(sw_fail), 32'h1);
        settle();
        chk("R5 disabled sources not ready", 32'(src_ready), 32'h8);
        chk("R6 boot source active", 32'(active_src), 32'h8);
        chk("R8 fail clear on match", 32'(sw_fail), 32'h0);

        unlock = 1'b1;
        wr_en(4'b1111);
        settle();
        chk("R5 all ready", 32'(src_ready), 32'hF);

        // table walk: R2 legal codes, R3 ignored codes
        for (int k = 0; k < 7; k++) begin
            wr_sel(VECS[k][9:7]);
            settle();
            chk("R2/R3 table sel", 32'(sel_code), 32'(VECS[k][6:4]));
            chk("R2/R3 table active", 32'(active_src), 32'(VECS[k][3:0]));
            chk("R8 table fail", 32'(sw_fail), 32'h0);
        end

        // R6: target not stable
        src_stable[2] = 1'b0;
        settle();
        chk("R5 unstable not ready", 32'(src_ready), 32'hB);
        wr_sel(3'b011);
        settle();
        chk("R6 sel updated", 32'(sel_code), 32'h3);
        chk("R6 held on old", 32'(active_src), 32'h8);
        chk("R8 fail pending", 32'(sw_fail), 32'h1);
        src_stable[2] = 1'b1;
        settle();
        chk("R6 completes", 32'(active_src), 32'h4);
        chk("R8 fail cleared", 32'(sw_fail), 32'h0);

        // R7: target disabled
        wr_en(4'b1101);
        wr_sel(3'b010);
        settle();
        chk("R7 target disabled holds", 32'(active_src), 32'h4);
        chk("R7 fail pending", 32'(sw_fail), 32'h1);
        wr_en(4'b1111);
        settle();
        chk("R7 target enabled completes", 32'(active_src), 32'h2);

        // R7: current source disabled
        wr_en(4'b1101);
        wr_sel(3'b000);
        settle();
        chk("R7 current disabled holds", 32'(active_src), 32'h2);
        chk("R7 fail pending", 32'(sw_fail), 32'h1);
        wr_en(4'b1111);
        settle();
        chk("R7 current enabled completes", 32'(active_src), 32'h1);
        chk("R8 fail cleared", 32'(sw_fail), 32'h0);

        // R10: active source loses stable
        src_stable[0] = 1'b0;
        settle();
        chk("R10 stays on source", 32'(active_src), 32'h1);
        chk("R10 fail stays low", 32'(sw_fail), 32'h0);
        chk("R10 ready drops", 32'(src_ready[0]), 32'h0);
        src_stable[0] = 1'b1;

        // R4: locked writes ignored
        unlock = 1'b0;
        wr_sel(3'b111);
        wr_en(4'b0000);
        settle();
        chk("R4 sel kept", 32'(sel_code), 32'h0);
        chk("R4 enables kept", 32'(src_en), 32'hF);
        chk("R4 active kept", 32'(active_src), 32'h1);

        // R1: crystal boot and an odd configuration value
        do_reset(3'b000);
        chk("R1 crystal boot sel", 32'(sel_code), 32'h0);
        chk("R1 crystal boot enables", 32'(src_en), 32'h9);
        chk("R1 no gate open", 32'(active_src), 32'h0);
        settle();
        chk("R1 crystal active", 32'(active_src), 32'h1);
        chk("R5 boot ready", 32'(src_ready), 32'h9);
        do_reset(3'b101);
        chk("R1 odd cfg sel", 32'(sel_code), 32'h7);
        chk("R1 odd cfg enables", 32'(src_en), 32'h8);
        settle();
        chk("R1 odd cfg active", 32'(active_src), 32'h8);

        chk("R9 short clock phases", 32'(glitches), 32'h0);
    endtask

    initial begin
        fork
            run_all();
            begin
                #200000;
                failures++;
                $display("FAIL watchdog actual=timeout expected=done");
            end
        join_any
        disable fork;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule